// File: doc/BRIEF.md
# Sub-Source Interrupt Aggregator

This block collects eleven peripheral sub-interrupts and folds them into four level-type request lines for a primary interrupt controller. Three serial ports each contribute three sub-sources: receive, transmit and error. A converter unit contributes two: a touch event and a conversion-done event. Each group drives one parent line.

Every sub-source has a pending bit that latches on the rising edge of its request. Every sub-source also has a mask bit. A pending bit counts toward its parent only while its mask bit is 0. Software reaches the pending bits, the mask bits and the eligible vector through a small synchronous register port. The eligible vector is pending AND NOT mask. Software reads it to find which sub-source inside a group raised the parent line. A pending bit is cleared by writing 1 to its position.

Top module: `subirq_agg`

## Requirements
- R1: After reset all pending bits are 0, all mask bits are 1 (mask reads 0x07FF) and all four parent lines are 0.
- R2: A 0-to-1 transition of request bit i sets pending bit i at the next clock edge. The bit stays set after the request falls. A request held high does not set the bit again once it has been cleared.
- R3: A write to register address 0 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 keep their value.
- R4: A request rise and a clear write to the same pending bit in the same cycle leave the bit set.
- R5: A write to register address 1 loads the mask from data bits 10:0. Data bits 15:11 read back as 0 at every address.
- R6: The eligible vector equals pending AND NOT mask. It is driven on `elig_o` and can be read at register address 2.
- R7: Sub-bits 3k, 3k+1 and 3k+2 belong to serial port k (k = 0, 1, 2), in the order receive, transmit, error, and drive `parent_irq_o[k]`. Sub-bit 9 (touch) and sub-bit 10 (conversion done) drive `parent_irq_o[3]`.
- R8: Each parent line is high exactly while at least one eligible bit of its group is set. It drops in the same clock cycle in which the last such bit is cleared or masked.
- R9: A masked sub-source still latches its pending bit. Unmasking it later raises its parent line.
- R10: A write to address 2 or address 3 changes neither the pending bits nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_req_i | input | 11 | Sub-source request levels |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe (valid with select) |
| bus_addr_i | input | 2 | Register address: 0 pending, 1 mask, 2 eligible |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register |
| parent_irq_o | output | 4 | Level request lines, one per group |
| elig_o | output | 11 | Pending AND NOT mask |

## Verification
Two operations can land on the same pending bit in one clock: a request edge that sets the bit, and a write-one-to-clear that removes it. The bench raises a request in the very cycle it issues a clear write for that bit. It expects the bit to read back set with its parent line high, since the newer event must not be lost. The bench repeats this with a rise on one bit and a clear of a neighbouring bit in the same cycle, and expects both operations to take effect.

// File: rtl/subirq_pkg.sv
`timescale 1ns/1ps
package subirq_pkg;
    localparam int SER_PORTS = 3;
    localparam int SER_BITS  = 3;
    localparam int CNV_BITS  = 2;
    localparam int N_SUB     = SER_PORTS * SER_BITS + CNV_BITS;
    localparam int N_GRP     = SER_PORTS + 1;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 2;

    typedef logic [N_SUB-1:0] sub_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_PEND = 2'd0,
        REG_MASK = 2'd1,
        REG_ELIG = 2'd2,
        REG_RSVD = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     wr_pend;
        logic     wr_mask;
        sub_vec_t wdata;
    } bus_cmd_t;

    // Member bits of group g: serial groups first, converter group last.
    function automatic sub_vec_t group_bits(input int g);
        sub_vec_t v;
        v = '0;
        if (g < SER_PORTS) begin
            for (int b = 0; b < SER_BITS; b++) v[g*SER_BITS + b] = 1'b1;
        end else begin
            for (int b = 0; b < CNV_BITS; b++) v[SER_PORTS*SER_BITS + b] = 1'b1;
        end
        return v;
    endfunction
endpackage

// File: rtl/subirq_bus_dec.sv
`timescale 1ns/1ps
module subirq_bus_dec
    import subirq_pkg::*;
(
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  sub_vec_t          pend_i,
    input  sub_vec_t          mask_i,
    input  sub_vec_t          elig_i,
    output bus_cmd_t          cmd_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int PAD_W = DATA_W - N_SUB;

    reg_sel_e sel_reg;
    sub_vec_t rd_val;
    logic     unused_hi;
    logic     wr_en;

    assign sel_reg   = reg_sel_e'(addr_i);
    assign wr_en     = sel_i & wr_i;
    assign unused_hi = ^wdata_i[DATA_W-1:N_SUB];

    always_comb begin
        cmd_o.wr_pend = wr_en && (sel_reg == REG_PEND);
        cmd_o.wr_mask = wr_en && (sel_reg == REG_MASK);
        cmd_o.wdata   = wdata_i[N_SUB-1:0];
    end

    always_comb begin
        unique case (sel_reg)
            REG_PEND: rd_val = pend_i;
            REG_MASK: rd_val = mask_i;
            REG_ELIG: rd_val = elig_i;
            default:  rd_val = '0;
        endcase
    end

    assign rdata_o = {{PAD_W{1'b0}}, rd_val};
endmodule

// File: rtl/subirq_pend.sv
`timescale 1ns/1ps
module subirq_pend
    import subirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sub_vec_t req_i,
    input  logic     clr_en_i,
    input  sub_vec_t clr_bits_i,
    output sub_vec_t pend_o
);
    sub_vec_t req_q;
    sub_vec_t rise;
    sub_vec_t clr;
    sub_vec_t pend_q;

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= req_i;
    end

    assign rise = req_i & ~req_q;
    assign clr  = clr_en_i ? clr_bits_i : '0;

    for (genvar i = 0; i < N_SUB; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)          pend_q[i] <= 1'b0;
            else if (rise[i]) pend_q[i] <= 1'b1;   // new event wins over clear
            else if (clr[i])  pend_q[i] <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    p_set_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

    p_no_spont_set_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(rise)) == '0));

    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (clr != '0) |=> ((pend_q & $past(clr & ~rise)) == '0));

    p_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (clr == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/subirq_mask.sv
`timescale 1ns/1ps
module subirq_mask
    import subirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_i,
    input  sub_vec_t wdata_i,
    output sub_vec_t mask_o
);
    sub_vec_t mask_q;

    always_ff @(posedge clk) begin
        if (rst)       mask_q <= '1;
        else if (wr_i) mask_q <= wdata_i;
    end

    assign mask_o = mask_q;

    p_mask_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '1));

    p_mask_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(mask_q));
endmodule

// File: rtl/subirq_group.sv
`timescale 1ns/1ps
module subirq_group
    import subirq_pkg::*;
(
    input  sub_vec_t         pend_i,
    input  sub_vec_t         mask_i,
    output sub_vec_t         elig_o,
    output logic [N_GRP-1:0] parent_o
);
    assign elig_o = pend_i & ~mask_i;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        localparam sub_vec_t MEMBERS = group_bits(g);
        assign parent_o[g] = |(elig_o & MEMBERS);
    end
endmodule

// File: rtl/subirq_agg.sv
`timescale 1ns/1ps
module subirq_agg
    import subirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_SUB-1:0]     sub_req_i,
    input  logic                 bus_sel_i,
    input  logic                 bus_wr_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    output logic [N_GRP-1:0]     parent_irq_o,
    output logic [N_SUB-1:0]     elig_o
);
    bus_cmd_t cmd;
    sub_vec_t pend;
    sub_vec_t mask;
    sub_vec_t elig;

    subirq_bus_dec u_dec (
        .sel_i   (bus_sel_i),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .pend_i  (pend),
        .mask_i  (mask),
        .elig_i  (elig),
        .cmd_o   (cmd),
        .rdata_o (bus_rdata_o)
    );

    subirq_pend u_pend (
        .clk        (clk),
        .rst        (rst),
        .req_i      (sub_req_i),
        .clr_en_i   (cmd.wr_pend),
        .clr_bits_i (cmd.wdata),
        .pend_o     (pend)
    );

    subirq_mask u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (cmd.wr_mask),
        .wdata_i (cmd.wdata),
        .mask_o  (mask)
    );

    subirq_group u_grp (
        .pend_i   (pend),
        .mask_i   (mask),
        .elig_o   (elig),
        .parent_o (parent_irq_o)
    );

    assign elig_o = elig;

    p_parent_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (elig_o == '0) |-> (parent_irq_o == '0));

    p_parent_src_r8: assert property (@(posedge clk) disable iff (rst)
        (parent_irq_o != '0) |-> (elig_o != '0));

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (parent_irq_o == '0 && elig_o == '0));

    p_reserved_write_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_sel_i && bus_wr_i && bus_addr_i[1]) |=> ($stable(elig_o)));
endmodule

// File: tb/subirq_agg_tb.sv
`timescale 1ns/1ps
module subirq_agg_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] req = '0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  parent;
    logic [10:0] elig;

    int n_chk = 0;
    int n_bad = 0;
    logic [10:0] m_pend = '0;
    logic [10:0] m_mask = 11'h7FF;
    logic [10:0] m_prev = '0;

    always #10 clk = ~clk;

    subirq_agg u_dut (
        .clk(clk), .rst(rst), .sub_req_i(req), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .parent_irq_o(parent), .elig_o(elig)
    );

    function automatic int grp_of(input int i);
        return (i < 9) ? i / 3 : 3;
    endfunction

    function automatic logic [3:0] exp_parent();
        logic [3:0] p = '0;
        logic [10:0] e = m_pend & ~m_mask;
        for (int i = 0; i < 11; i++) if (e[i]) p[grp_of(i)] = 1'b1;
        return p;
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    // One clock with request levels r and an optional write; model follows requirements.
    task automatic cyc(input logic [10:0] r, input bit do_wr, input logic [1:0] a, input logic [15:0] d);
        logic [10:0] rise;
        req = r; sel = do_wr; wr = do_wr; addr = a; wdata = d;
        @(posedge clk);
        rise = r & ~m_prev;
        if (do_wr && a == 2'd0) m_pend = m_pend & ~d[10:0];
        if (do_wr && a == 2'd1) m_mask = d[10:0];
        m_pend = m_pend | rise;
        m_prev = r;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        addr = a; #1; v = rdata;
    endtask

    task automatic check_state(input string tag);
        logic [15:0] v;
        rd(2'd0, v); chk({tag, " pending"}, v, {5'b0, m_pend});
        rd(2'd1, v); chk({tag, " mask"}, v, {5'b0, m_mask});
        rd(2'd2, v); chk({tag, " R6 eligible read"}, v, {5'b0, m_pend & ~m_mask});
        chk({tag, " R6 eligible port"}, {5'b0, elig}, {5'b0, m_pend & ~m_mask});
        chk({tag, " R8 parent"}, {12'b0, parent}, {12'b0, exp_parent()});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog got=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_state("R1 reset");

        // R5: mask write, upper bits read zero
        cyc('0, 1, 2'd1, 16'hFFFF);
        rd(2'd1, v); chk("R5 mask upper bits", v, 16'h07FF);
        cyc('0, 1, 2'd1, 16'h0000);
        check_state("R5 mask cleared");

        // R2/R7/R8: single-bit sweep
        for (int i = 0; i < 11; i++) begin
            cyc(11'(1 << i), 0, 2'd0, '0);
            check_state($sformatf("R2 rise bit %0d", i));
            chk($sformatf("R7 group of bit %0d", i), {12'b0, parent}, 16'(1 << grp_of(i)));
            cyc('0, 0, 2'd0, '0);
            check_state($sformatf("R2 latched bit %0d", i));
            cyc('0, 1, 2'd0, 16'(1 << i));
            check_state($sformatf("R3 clear bit %0d", i));
            chk($sformatf("R8 parent drop bit %0d", i), {12'b0, parent}, 16'h0);
        end

        // R3: write of zeros leaves bits
        cyc(11'h7FF, 0, 2'd0, '0);
        cyc('0, 1, 2'd0, 16'h0005);
        rd(2'd0, v); chk("R3 partial clear", v, 16'h07FA);

        // R8/R6: sweep mask patterns with all pending
        cyc('0, 1, 2'd0, 16'hFFFF);
        cyc(11'h7FF, 0, 2'd0, '0);
        cyc('0, 0, 2'd0, '0);
        for (int k = 0; k < 48; k++) begin
            cyc('0, 1, 2'd1, 16'((k * 16'h2F3 + k * k * 7) & 16'h07FF));
            check_state($sformatf("R8 mask pattern %0d", k));
        end
        for (int g = 0; g < 4; g++) begin
            cyc('0, 1, 2'd1, 16'(~32'(g < 3 ? (7 << (3 * g)) : (3 << 9)) & 32'h7FF));
            chk($sformatf("R7 only group %0d", g), {12'b0, parent}, 16'(1 << g));
        end

        // R8: converter group drops only after its last bit
        cyc('0, 1, 2'd1, 16'h0000);
        cyc('0, 1, 2'd0, 16'h01FF);
        check_state("R8 converter pair");
        cyc('0, 1, 2'd0, 16'h0200);
        check_state("R8 one converter bit left");
        chk("R8 parent3 still high", {12'b0, parent}, 16'h0008);
        cyc('0, 1, 2'd0, 16'h0400);
        chk("R8 parent3 dropped", {12'b0, parent}, 16'h0000);

        // R9: masked source still latches
        cyc('0, 1, 2'd1, 16'h07FF);
        cyc(11'h010, 0, 2'd0, '0);
        check_state("R9 masked latch");
        chk("R9 parent stays low", {12'b0, parent}, 16'h0);
        cyc('0, 1, 2'd1, 16'h07EF);
        chk("R9 unmask raises", {12'b0, parent}, 16'h0002);
        cyc('0, 1, 2'd1, 16'h0000);
        cyc('0, 1, 2'd0, 16'hFFFF);

        // R2: held-high request does not re-set
        cyc(11'h001, 0, 2'd0, '0);
        cyc(11'h001, 1, 2'd0, 16'h0001);
        repeat (3) cyc(11'h001, 0, 2'd0, '0);
        rd(2'd0, v); chk("R2 held high no reset", v, 16'h0000);
        cyc('0, 0, 2'd0, '0);

        // R4: collision, set wins; neighbouring bits independent
        cyc(11'h004, 1, 2'd0, 16'h0004);
        rd(2'd0, v); chk("R4 same-bit collision", v, 16'h0004);
        check_state("R4 collision state");
        cyc(11'h010, 0, 2'd0, '0);
        cyc(11'h018, 1, 2'd0, 16'h0010);
        rd(2'd0, v); chk("R4 rise bit3 clear bit4", v, 16'h000C);

        // R10: reserved/read-only addresses ignore writes
        cyc(11'h018, 1, 2'd1, 16'h0123);
        cyc(11'h018, 1, 2'd2, 16'hFFFF);
        check_state("R10 write addr2");
        cyc(11'h018, 1, 2'd3, 16'hFFFF);
        check_state("R10 write addr3");
        rd(2'd3, v); chk("R10 addr3 reads zero", v, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule